// File: doc/BRIEF.md
# Strap-configured ROM slave bus interface

This block is the bus-facing control of an on-chip read-only memory. It answers a simple synchronous bus: a byte address, a 16-bit write word, single-cycle read and write strobes, and a registered acknowledge with read data. It recognises three areas: a small register block at a fixed base, a fixed bootstrap range at address zero that returns four start-up words, and a relocatable array window. The array window is aligned to the array size, and its contents come from a computed lookup.

While master reset is held, the block samples three strap lines taken from the data bus. These lines set two flags. The disable (stop) flag silences both the bootstrap range and the array window, so that an external device can answer there. The emulation flag redirects array accesses to an external emulation memory through a one-cycle select pulse. Software can clear either flag through the configuration register. A lock bit freezes the array base. A build option removes the bootstrap response entirely.

There is no back-pressure and no valid/ready handshake. Each strobe gets its answer, acknowledge or select or nothing, exactly one clock later. The master must hold a strobe high for one clock only and must not issue a new strobe in the answer cycle.

Top module: `rombi_top`

## Requirements
- R1: While `rst_n` is low, `strap_stop` is sampled; the stop flag (config register bit 15, offset 0x00) comes out of reset as the inverse of that line.
- R2: The emulation flag (config bit 14) comes out of reset as 1 only when `strap_emu_in` and `strap_emu_en` were both 0 during reset, otherwise 0.
- R3: The lock bit (config bit 13) resets to parameter `LOCK_DEF`. Writing 1 sets it. Writing 0 does not clear it.
- R4: The register block (addresses `REG_BASE`..`REG_BASE`+0x3F) always acknowledges, even with stop set. Reads return config at 0x00, base high byte at 0x04, base low word at 0x06, bootstrap words 0..3 at 0x30/0x32/0x34/0x36, and 0 elsewhere.
- R5: With stop = 1, accesses to the bootstrap range and to the array window get neither acknowledge nor emulation select. Writing bit 15 = 0 to config restores both regions.
- R6: With parameter `NO_BOOT` = 1, the bootstrap range never acknowledges, whatever the stop flag.
- R7: A read of bootstrap address 2*i (i = 0..3) returns bootstrap word i. Word 3 is the start PC low half. It also reads at register offset 0x36, and its value is a build parameter.
- R8: The array window covers addresses whose bits above `ARRAY_AW` match the base. The low `ARRAY_AW` bits of the base read as 0. A read of word index k in the window returns the low 16 bits of k*`ROM_MUL`+`ROM_ADD`.
- R9: An acknowledged access raises `ack` for exactly the one clock after the strobe. `rdata` carries the read word in that clock and is 0 at all other times, and is 0 for writes.
- R10: With emulation = 1 and stop = 0, an array read or write gives one clock of `emul_sel` instead of `ack`, with `rdata` 0.
- R11: While lock = 1, writes to the base registers (0x04, 0x06) leave the base unchanged.
- R12: Writes to the array or bootstrap range are acknowledged and change nothing. Odd addresses and addresses outside all three areas get no answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| strap_stop | input | 1 | Strap line sampled in reset; 0 disables the array and bootstrap |
| strap_emu_in | input | 1 | Strap line sampled in reset for emulation |
| strap_emu_en | input | 1 | Strap line sampled in reset for emulation |
| addr | input | ADDR_W | Byte address |
| wdata | input | 16 | Write word |
| rd | input | 1 | Read strobe, one clock |
| wr | input | 1 | Write strobe, one clock |
| ack | output | 1 | Access accepted, one clock after the strobe |
| rdata | output | 16 | Read word, valid with `ack` |
| emul_sel | output | 1 | Emulation memory select pulse |

## Verification
The bench builds two copies that share one bus. The first uses the defaults (`NO_BOOT` = 0, `LOCK_DEF` = 0, a 1 KiB array, bootstrap PC word 0x0400). It reaches relocation of the window, locking after a software write, and reset with each strap combination. The second has `NO_BOOT` = 1 and `LOCK_DEF` = 1. It shows the bootstrap range silent while the array answers, and a lock that is active from reset, so base writes are refused from the first access.

// File: rtl/rombi_pkg.sv
package rombi_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_REG,
    RG_BOOT,
    RG_ARRAY,
    RG_EMUL
  } region_e;

  localparam logic [5:0] OFF_CFG = 6'h00;
  localparam logic [5:0] OFF_BHI = 6'h04;
  localparam logic [5:0] OFF_BLO = 6'h06;
  localparam logic [5:0] OFF_BW0 = 6'h30;
  localparam logic [5:0] OFF_BW1 = 6'h32;
  localparam logic [5:0] OFF_BW2 = 6'h34;
  localparam logic [5:0] OFF_BW3 = 6'h36;

  localparam int CFG_STOP_BIT = 15;
  localparam int CFG_EMUL_BIT = 14;
  localparam int CFG_LOCK_BIT = 13;

  // computed array contents: word k -> low half of k*mul+add
  function automatic logic [15:0] rom_word(logic [15:0] idx, logic [15:0] mul,
                                           logic [15:0] add);
    logic [15:0] prod;
    prod = idx * mul;
    return prod + add;
  endfunction

endpackage

// File: rtl/rombi_cfg_regs.sv
module rombi_cfg_regs
  import rombi_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          ARRAY_AW = 10,
  parameter logic [ADDR_W-1:0] BASE_RST = 24'h004000,
  parameter bit          LOCK_DEF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_stop,
  input  logic              strap_emu_in,
  input  logic              strap_emu_en,
  input  logic              wr_en,
  input  logic [5:0]        woff,
  input  logic [15:0]       wdata,
  output logic              stop_q,
  output logic              emul_q,
  output logic              lock_q,
  output logic [ADDR_W-1:0] base_q
);

  localparam int HI_W = ADDR_W - 16;
  localparam logic [15:0] LO_MASK = ~((16'(1) << ARRAY_AW) - 16'(1));
  localparam logic [ADDR_W-1:0] BASE_INIT = {BASE_RST[ADDR_W-1:16], BASE_RST[15:0] & LO_MASK};

  logic cfg_we, bhi_we, blo_we;

  always_comb begin
    cfg_we = wr_en && (woff == OFF_CFG);
    bhi_we = wr_en && (woff == OFF_BHI) && !lock_q;
    blo_we = wr_en && (woff == OFF_BLO) && !lock_q;
  end

  // flags are captured from strap lines for as long as reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= ~strap_stop;
      emul_q <= ~(strap_emu_in | strap_emu_en);
      lock_q <= LOCK_DEF;
    end else if (cfg_we) begin
      stop_q <= wdata[CFG_STOP_BIT];
      emul_q <= wdata[CFG_EMUL_BIT];
      lock_q <= lock_q | wdata[CFG_LOCK_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= BASE_INIT;
    end else begin
      if (bhi_we) base_q[ADDR_W-1:16] <= wdata[HI_W-1:0];
      if (blo_we) base_q[15:0]        <= wdata & LO_MASK;
    end
  end

endmodule

// File: rtl/rombi_decode.sv
module rombi_decode
  import rombi_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          ARRAY_AW = 10,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'hFFF800,
  parameter bit          NO_BOOT  = 1'b0
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-ARRAY_AW-1:0] base_tag,
  input  logic                     stop,
  input  logic                     emul,
  output region_e                  rg
);

  logic reg_hit, boot_hit, arr_hit;

  always_comb begin
    reg_hit  = addr[ADDR_W-1:6] == REG_BASE[ADDR_W-1:6];
    boot_hit = addr[ADDR_W-1:3] == '0;
    arr_hit  = addr[ADDR_W-1:ARRAY_AW] == base_tag;
  end

  generate
    if (NO_BOOT) begin : g_noboot
      always_comb begin
        rg = RG_NONE;
        if (addr[0])                          rg = RG_NONE;
        else if (reg_hit)                     rg = RG_REG;
        else if (boot_hit)                    rg = RG_NONE;
        else if (arr_hit && !stop)            rg = emul ? RG_EMUL : RG_ARRAY;
      end
    end else begin : g_boot
      always_comb begin
        rg = RG_NONE;
        if (addr[0])                          rg = RG_NONE;
        else if (reg_hit)                     rg = RG_REG;
        else if (boot_hit)                    rg = stop ? RG_NONE : RG_BOOT;
        else if (arr_hit && !stop)            rg = emul ? RG_EMUL : RG_ARRAY;
      end
    end
  endgenerate

endmodule

// File: rtl/rombi_rdmux.sv
module rombi_rdmux
  import rombi_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          ARRAY_AW = 10,
  parameter logic [15:0] BOOT_W0  = 16'h0000,
  parameter logic [15:0] BOOT_W1  = 16'h2000,
  parameter logic [15:0] BOOT_W2  = 16'h0000,
  parameter logic [15:0] BOOT_W3  = 16'h0400,
  parameter logic [15:0] ROM_MUL  = 16'h9E37,
  parameter logic [15:0] ROM_ADD  = 16'h1234
) (
  input  region_e           rg,
  input  logic [4:0]        off_w,
  input  logic [ARRAY_AW-2:0] arr_idx,
  input  logic              stop_q,
  input  logic              emul_q,
  input  logic              lock_q,
  input  logic [ADDR_W-1:0] base_q,
  output logic [15:0]       rword
);

  logic [15:0] boot_word, reg_word, arr_word;
  logic [5:0]  off;

  always_comb begin
    off = {off_w, 1'b0};
    unique case (off_w[1:0])
      2'd0:    boot_word = BOOT_W0;
      2'd1:    boot_word = BOOT_W1;
      2'd2:    boot_word = BOOT_W2;
      default: boot_word = BOOT_W3;
    endcase
    case (off)
      OFF_CFG: reg_word = {stop_q, emul_q, lock_q, 13'd0};
      OFF_BHI: reg_word = {{(32-ADDR_W){1'b0}}, base_q[ADDR_W-1:16]};
      OFF_BLO: reg_word = base_q[15:0];
      OFF_BW0: reg_word = BOOT_W0;
      OFF_BW1: reg_word = BOOT_W1;
      OFF_BW2: reg_word = BOOT_W2;
      OFF_BW3: reg_word = BOOT_W3;
      default: reg_word = 16'd0;
    endcase
    arr_word = rom_word(16'(arr_idx), ROM_MUL, ROM_ADD);
    case (rg)
      RG_REG:   rword = reg_word;
      RG_BOOT:  rword = boot_word;
      RG_ARRAY: rword = arr_word;
      default:  rword = 16'd0;
    endcase
  end

endmodule

// File: rtl/rombi_top.sv
module rombi_top
  import rombi_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          ARRAY_AW = 10,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'hFFF800,
  parameter logic [ADDR_W-1:0] BASE_RST = 24'h004000,
  parameter bit          LOCK_DEF = 1'b0,
  parameter bit          NO_BOOT  = 1'b0,
  parameter logic [15:0] BOOT_W0  = 16'h0000,
  parameter logic [15:0] BOOT_W1  = 16'h2000,
  parameter logic [15:0] BOOT_W2  = 16'h0000,
  parameter logic [15:0] BOOT_W3  = 16'h0400,
  parameter logic [15:0] ROM_MUL  = 16'h9E37,
  parameter logic [15:0] ROM_ADD  = 16'h1234
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_stop,
  input  logic              strap_emu_in,
  input  logic              strap_emu_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              rd,
  input  logic              wr,
  output logic              ack,
  output logic [15:0]       rdata,
  output logic              emul_sel
);

  logic              stop_q, emul_q, lock_q;
  logic [ADDR_W-1:0] base_q;
  region_e           rg;
  logic [15:0]       rword;
  logic              answerable;

  rombi_cfg_regs #(
    .ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .BASE_RST(BASE_RST), .LOCK_DEF(LOCK_DEF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .strap_stop(strap_stop), .strap_emu_in(strap_emu_in), .strap_emu_en(strap_emu_en),
    .wr_en(wr && (rg == RG_REG)), .woff(addr[5:0]), .wdata(wdata),
    .stop_q(stop_q), .emul_q(emul_q), .lock_q(lock_q), .base_q(base_q)
  );

  rombi_decode #(
    .ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .REG_BASE(REG_BASE), .NO_BOOT(NO_BOOT)
  ) u_dec (
    .addr(addr), .base_tag(base_q[ADDR_W-1:ARRAY_AW]),
    .stop(stop_q), .emul(emul_q), .rg(rg)
  );

  rombi_rdmux #(
    .ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW),
    .BOOT_W0(BOOT_W0), .BOOT_W1(BOOT_W1), .BOOT_W2(BOOT_W2), .BOOT_W3(BOOT_W3),
    .ROM_MUL(ROM_MUL), .ROM_ADD(ROM_ADD)
  ) u_mux (
    .rg(rg), .off_w(addr[5:1]), .arr_idx(addr[ARRAY_AW-1:1]),
    .stop_q(stop_q), .emul_q(emul_q), .lock_q(lock_q), .base_q(base_q),
    .rword(rword)
  );

  always_comb answerable = (rg == RG_REG) || (rg == RG_BOOT) || (rg == RG_ARRAY);

  // single registered answer stage: everything lands one clock after the strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      rdata    <= 16'd0;
      emul_sel <= 1'b0;
    end else begin
      ack      <= (rd || wr) && answerable;
      rdata    <= (rd && answerable) ? rword : 16'd0;
      emul_sel <= (rd || wr) && (rg == RG_EMUL);
    end
  end

endmodule

// File: rtl/rombi_chk.sv
module rombi_chk
  import rombi_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd,
  input logic              wr,
  input logic              ack,
  input logic [15:0]       rdata,
  input logic              emul_sel,
  input logic              stop_q,
  input logic              lock_q,
  input logic [ADDR_W-1:0] base_q,
  input region_e           rg
);

  a_r9_ack_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || emul_sel) |-> $past(rd || wr));

  a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (rdata == 16'd0));

  a_r10_select_excludes_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && emul_sel));

  a_r5_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && stop_q && (rg != RG_REG)) |=> (!ack && !emul_sel));

  a_r4_regs_always_answer: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && (rg == RG_REG)) |=> ack);

  a_r11_lock_freezes_base: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(base_q));

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

endmodule

bind rombi_top rombi_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .ack(ack), .rdata(rdata),
  .emul_sel(emul_sel), .stop_q(stop_q), .lock_q(lock_q), .base_q(base_q), .rg(rg)
);

// File: tb/rombi_top_tb.sv
`timescale 1ns/1ps
module rombi_top_tb;

  localparam logic [23:0] REG_BASE = 24'hFFF800;
  localparam logic [23:0] BASE_RST = 24'h004000;
  localparam logic [15:0] LO_MASK  = 16'hFC00;
  localparam logic [15:0] MUL = 16'h9E37, ADD = 16'h1234;
  localparam logic [15:0] BW0 = 16'h0000, BW1 = 16'h2000, BW2 = 16'h0000, BW3 = 16'h0400;

  logic clk = 0, rst_n = 0;
  logic s_stop = 1, s_ein = 1, s_een = 1;
  logic [23:0] addr = 0;
  logic [15:0] wdata = 0;
  logic rd = 0, wr = 0;
  logic ack, emul_sel, ack_nb, esel_nb;
  logic [15:0] rdata, rdata_nb;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic m_stop, m_emul, m_lock; logic [23:0] m_base;
  logic n_stop, n_emul;         logic [23:0] n_base;

  always #2 clk = ~clk;

  rombi_top u_dut (
    .clk(clk), .rst_n(rst_n), .strap_stop(s_stop), .strap_emu_in(s_ein), .strap_emu_en(s_een),
    .addr(addr), .wdata(wdata), .rd(rd), .wr(wr), .ack(ack), .rdata(rdata), .emul_sel(emul_sel));

  rombi_top #(.NO_BOOT(1'b1), .LOCK_DEF(1'b1)) u_dut_nb (
    .clk(clk), .rst_n(rst_n), .strap_stop(s_stop), .strap_emu_in(s_ein), .strap_emu_en(s_een),
    .addr(addr), .wdata(wdata), .rd(rd), .wr(wr), .ack(ack_nb), .rdata(rdata_nb),
    .emul_sel(esel_nb));

  task automatic check(bit ok, string tag, logic [17:0] act, logic [17:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual ack/sel/data=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] arr_word(logic [23:0] a);
    logic [15:0] p;
    p = 16'(a[9:1]) * MUL;
    return p + ADD;
  endfunction

  // returns {ack, emul_sel, rdata}
  function automatic logic [17:0] expect_resp(logic [23:0] a, bit is_wr, logic stp, logic emu,
                                              logic lck, logic [23:0] base, bit noboot);
    logic [15:0] d;
    d = 0;
    if (a[0]) return 18'd0;
    if (a[23:6] == REG_BASE[23:6]) begin
      case ({a[5:1], 1'b0})
        6'h00: d = {stp, emu, lck, 13'd0};
        6'h04: d = {8'd0, base[23:16]};
        6'h06: d = base[15:0];
        6'h30: d = BW0;
        6'h32: d = BW1;
        6'h34: d = BW2;
        6'h36: d = BW3;
        default: d = 0;
      endcase
      return {2'b10, is_wr ? 16'd0 : d};
    end
    if (a[23:3] == 0) begin
      if (stp || noboot) return 18'd0;
      case (a[2:1])
        2'd0: d = BW0; 2'd1: d = BW1; 2'd2: d = BW2; default: d = BW3;
      endcase
      return {2'b10, is_wr ? 16'd0 : d};
    end
    if (a[23:10] == base[23:10] && !stp) begin
      if (emu) return {2'b01, 16'd0};
      return {2'b10, is_wr ? 16'd0 : arr_word(a)};
    end
    return 18'd0;
  endfunction

  function automatic void model_write(logic [23:0] a, logic [15:0] d, inout logic stp,
                                      inout logic emu, inout logic lck, inout logic [23:0] base);
    if (a[0] || a[23:6] != REG_BASE[23:6]) return;
    case ({a[5:1], 1'b0})
      6'h00: begin stp = d[15]; emu = d[14]; lck = lck | d[13]; end
      6'h04: if (!lck) base[23:16] = d[7:0];
      6'h06: if (!lck) base[15:0] = d & LO_MASK;
      default: ;
    endcase
  endfunction

  task automatic access(bit is_wr, logic [23:0] a, logic [15:0] d, string tag);
    logic [17:0] e, en, got, gotn;
    logic nb_lock;
    nb_lock = 1'b1;
    e  = expect_resp(a, is_wr, m_stop, m_emul, m_lock, m_base, 1'b0);
    en = expect_resp(a, is_wr, n_stop, n_emul, nb_lock, n_base, 1'b1);
    @(negedge clk);
    addr = a; wdata = d; rd = !is_wr; wr = is_wr;
    @(negedge clk);
    rd = 0; wr = 0;
    got  = {ack, emul_sel, rdata};
    gotn = {ack_nb, esel_nb, rdata_nb};
    check(got == e, tag, got, e);
    check(gotn == en, {tag, " (no-boot copy)"}, gotn, en);
    @(negedge clk);
    // R9: answer lasts one clock, data returns to zero
    check({ack, emul_sel, rdata} == 18'd0, "R9", {ack, emul_sel, rdata}, 18'd0);
    if (is_wr) begin
      model_write(a, d, m_stop, m_emul, m_lock, m_base);
      model_write(a, d, n_stop, n_emul, nb_lock, n_base);
    end
  endtask

  task automatic do_reset(logic st, logic ei, logic ee);
    @(negedge clk);
    rst_n = 0; s_stop = st; s_ein = ei; s_een = ee; rd = 0; wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_stop = ~st; m_emul = ~(ei | ee); m_lock = 0; m_base = BASE_RST;
    n_stop = ~st; n_emul = ~(ei | ee); n_base = BASE_RST;
    // straps change after reset and must have no effect
    s_stop = ~st; s_ein = ~ei; s_een = ~ee;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] a;
    void'($urandom(32'h5EED_0042));
    // plain reset: straps high -> running, no emulation
    do_reset(1, 1, 1);
    check({ack, emul_sel, rdata} == 0, "R9", {ack, emul_sel, rdata}, 0);
    access(0, REG_BASE + 24'h00, 0, "R1");                   // R1 R2 R3 config readback
    access(0, REG_BASE + 24'h36, 0, "R7");
    access(0, 24'h000006, 0, "R7");
    access(0, 24'h000002, 0, "R7");
    access(0, BASE_RST + 24'h0002, 0, "R8");
    access(0, BASE_RST + 24'h03FE, 0, "R8");
    access(0, BASE_RST + 24'h0400, 0, "R12");
    access(0, BASE_RST + 24'h0003, 0, "R12");
    access(1, BASE_RST + 24'h0010, 16'hFFFF, "R12");
    access(0, BASE_RST + 24'h0010, 0, "R12");
    access(1, REG_BASE + 24'h20, 16'hABCD, "R4");
    access(0, REG_BASE + 24'h20, 0, "R4");
    // relocate window, read new and old
    access(1, REG_BASE + 24'h04, 16'h0012, "R8");
    access(1, REG_BASE + 24'h06, 16'h37FF, "R8");
    access(0, REG_BASE + 24'h06, 0, "R8");
    access(0, 24'h123404, 0, "R8");
    access(0, BASE_RST + 24'h0004, 0, "R8");
    // lock then try to move
    access(1, REG_BASE + 24'h00, 16'h2000, "R3");
    access(1, REG_BASE + 24'h00, 16'h0000, "R3");
    access(0, REG_BASE + 24'h00, 0, "R3");
    access(1, REG_BASE + 24'h04, 16'h0055, "R11");
    access(1, REG_BASE + 24'h06, 16'h8000, "R11");
    access(0, REG_BASE + 24'h04, 0, "R11");
    access(0, 24'h123400, 0, "R11");

    // stop strap low: regions silent, registers live
    do_reset(0, 1, 0);
    access(0, REG_BASE + 24'h00, 0, "R1");
    access(0, 24'h000006, 0, "R5");
    access(0, BASE_RST, 0, "R5");
    access(1, BASE_RST, 16'h1, "R5");
    access(1, REG_BASE + 24'h00, 16'h0000, "R5");
    access(0, 24'h000006, 0, "R5");                          // R6 via no-boot copy
    access(0, BASE_RST + 24'h0020, 0, "R6");

    // emulation straps both low
    do_reset(1, 0, 0);
    access(0, REG_BASE + 24'h00, 0, "R2");
    access(0, BASE_RST + 24'h0008, 0, "R10");
    access(1, BASE_RST + 24'h0008, 16'h5, "R10");
    access(0, 24'h000000, 0, "R10");
    do_reset(0, 0, 0);
    access(0, BASE_RST + 24'h0008, 0, "R5");
    access(1, REG_BASE + 24'h00, 16'h4000, "R10");
    access(0, BASE_RST + 24'h0008, 0, "R10");
    access(1, REG_BASE + 24'h00, 16'h0000, "R10");
    access(0, BASE_RST + 24'h0008, 0, "R8");
    do_reset(1, 0, 1);
    access(0, REG_BASE + 24'h00, 0, "R2");

    // constrained random mix
    do_reset(1, 1, 1);
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [15:0] d;
      sel = $urandom_range(0, 9);
      d = 16'($urandom);
      case (sel)
        0, 1: a = REG_BASE + 24'($urandom_range(0, 63));
        2, 3: a = 24'($urandom_range(0, 15));
        4, 5, 6: a = m_base + 24'($urandom_range(0, 1023));
        default: a = 24'($urandom);
      endcase
      if (sel < 2 && a[5:1] == 0) d = d & 16'h1FFF;          // keep stop/emul/lock mostly clear
      access($urandom_range(0, 3) == 0, a, d, "R12");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule